// File: doc/BRIEF.md
# Tag-Synchronized Shared Scratchpad

This block is a small shared word memory that several producer and consumer ports use to pass data to each other with no separate flag traffic. Each word carries two hardware tags next to its data: a presence bit and a count of reads still owed. A producer's write fills the word, raises the presence bit and loads the owed-read count. Each consumer read returns the word and uses up one owed read. When the last owed read is taken, the presence bit drops and the word may be written again.

A consumer that asks for a word that is not present is held off until some producer fills it. A producer that targets a word that is still present is held off until every owed read has been taken. Each request names a start address and a burst length. A burst walks consecutive words, one word per grant. It keeps its place when it stalls part way through and continues from that word.

Each cycle, a round-robin arbiter picks one port from those whose current word can proceed. Read data comes back one cycle after the grant and is tagged with the port that asked for it.

Top module: `ssm_sync_scratchpad`

## Requirements
- R1: After reset every word is absent. No grant is issued and `rd_valid` stays low until a word is stored.
- R2: A granted store writes the word, marks it present and sets its owed-read count to the `st_cnt` value. A `st_cnt` of zero is taken as one.
- R3: A load to an absent word receives no grant. A granted load returns the word on `rd_data`, with `rd_valid` high and the port number on `rd_port`, in the cycle after the grant.
- R4: Each granted load lowers the word's count by one. The load that takes the last owed read marks the word absent, and a later load to it stalls until a new store.
- R5: A store to a present word receives no grant until the word's owed reads have all been taken.
- R6: `req_len` holds the burst length minus one. Element k of a burst uses address (`req_addr` + k) modulo 2^AW. Each grant moves exactly one element, and `done` is high together with the grant of the final element.
- R7: A burst that stalls part way through keeps its element index and resumes from that element, with no element repeated or skipped.
- R8: When several ports can proceed, grants rotate. After port p is granted, the search for the next grant starts at port p+1, wrapping round.
- R9: A cycle with `init` high marks every word absent and issues no grant.
- R10: At most one port is granted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| init | input | 1 | Mark every word absent this cycle |
| req | input | NPORTS | Per-port request, held until the last element is granted |
| req_st | input | NPORTS | Per-port operation: 1 store, 0 load |
| req_addr | input | NPORTS*AW | Per-port burst start address |
| req_len | input | NPORTS*LW | Per-port burst length minus one |
| st_data | input | NPORTS*DW | Per-port store data for the current element |
| st_cnt | input | NPORTS*CW | Per-port owed-read count for stores |
| gnt | output | NPORTS | Current element of that port accepted this cycle |
| done | output | NPORTS | Grant of the burst's final element |
| rd_valid | output | 1 | Load data valid |
| rd_port | output | PW | Port that issued the returned load |
| rd_data | output | DW | Returned word |

## Verification
The bench builds the block with three ports, an 8-word memory (AW=3), a 2-bit count and a 3-bit length. With an 8-word memory, a four-word burst starting at word 6 wraps past the top address. With three ports competing, a broken rotation shows up as a wrong port order within six grants. The bench sends a store to a word that is still present and a load to a word that is absent. It stalls a burst between elements and raises `init` while a store is pending. In each case the returned data shows whether the tags gated the access correctly.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_e;

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ssm_rr_arb.sv
module ssm_rr_arb #(
  parameter int NPORTS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [NPORTS-1:0] elig,
  output logic [NPORTS-1:0] gnt
);
  localparam int PW = ssm_pkg::idx_w(NPORTS);

  logic [PW-1:0] ptr_q, ptr_nx;
  logic          found;

  always_comb begin
    gnt    = '0;
    found  = 1'b0;
    ptr_nx = ptr_q;
    for (int o = 0; o < NPORTS; o++) begin
      if (en && !found && elig[(int'(ptr_q) + o) % NPORTS]) begin
        gnt[(int'(ptr_q) + o) % NPORTS] = 1'b1;
        found  = 1'b1;
        ptr_nx = PW'((((int'(ptr_q) + o) % NPORTS) + 1) % NPORTS);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (found) ptr_q <= ptr_nx;
  end

  a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r8_grant_only_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~elig) == '0);
endmodule

// File: rtl/ssm_port_seq.sv
module ssm_port_seq #(
  parameter int AW = 3,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          gnt,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] ea,
  output logic          last
);
  logic [LW-1:0] idx_q, idx_nx;

  assign last = (idx_q == len);
  assign ea   = base + AW'(idx_q);

  always_comb begin
    idx_nx = idx_q;
    if (!req)     idx_nx = '0;
    else if (gnt) idx_nx = last ? '0 : idx_q + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_nx;
  end

  a_r6_next_word: assert property (@(posedge clk) disable iff (!rst_n)
    (req && gnt && !last) |=> (!req || ea == $past(ea) + AW'(1)));
  a_r7_hold_index: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt) |=> (!req || $stable(ea)));
endmodule

// File: rtl/ssm_tag_mem.sv
module ssm_tag_mem #(
  parameter int AW = 3,
  parameter int DW = 16,
  parameter int CW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [CW-1:0]     cnt_in,
  output logic [(1<<AW)-1:0] valid_o,
  output logic [DW-1:0]     rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [CW-1:0]    cnt_q [DEPTH];
  logic [DEPTH-1:0] valid_q, valid_nx;
  logic [CW-1:0]    cur_cnt, cnt_nx;
  logic [DW-1:0]    rdata_q, rdata_nx;
  logic             cnt_en;

  assign cur_cnt = cnt_q[addr];
  assign cnt_en  = (wr_en || rd_en) && !init;

  always_comb begin
    cnt_nx   = wr_en ? ((cnt_in == '0) ? CW'(1) : cnt_in) : cur_cnt - CW'(1);
    valid_nx = valid_q;
    if (init)                               valid_nx = '0;
    else if (wr_en)                         valid_nx[addr] = 1'b1;
    else if (rd_en && cur_cnt == CW'(1))    valid_nx[addr] = 1'b0;
    rdata_nx = rd_en ? mem_q[addr] : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rdata_q <= '0;
    end else begin
      valid_q <= valid_nx;
      rdata_q <= rdata_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
    end else if (cnt_en) begin
      cnt_q[addr] <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[addr] <= wdata;
  end

  assign valid_o = valid_q;
  assign rdata_o = rdata_q;

  a_r2_store_marks_present: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !init) |=> valid_q[$past(addr)]);
  a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !init) |=> cnt_q[$past(addr)] != '0);
  a_r4_last_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !init && cur_cnt == CW'(1)) |=> !valid_q[$past(addr)]);
  a_r9_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> valid_q == '0);
  a_r3_read_needs_present: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> valid_q[addr]);
  a_r5_write_needs_absent: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !valid_q[addr]);
endmodule

// File: rtl/ssm_sync_scratchpad.sv
module ssm_sync_scratchpad #(
  parameter int NPORTS = 3,
  parameter int AW     = 4,
  parameter int DW     = 16,
  parameter int CW     = 3,
  parameter int LW     = 4,
  localparam int PW    = ssm_pkg::idx_w(NPORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic [NPORTS-1:0]    req,
  input  logic [NPORTS-1:0]    req_st,
  input  logic [NPORTS*AW-1:0] req_addr,
  input  logic [NPORTS*LW-1:0] req_len,
  input  logic [NPORTS*DW-1:0] st_data,
  input  logic [NPORTS*CW-1:0] st_cnt,
  output logic [NPORTS-1:0]    gnt,
  output logic [NPORTS-1:0]    done,
  output logic                 rd_valid,
  output logic [PW-1:0]        rd_port,
  output logic [DW-1:0]        rd_data
);
  import ssm_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic             rst_meta, rst_i;
  logic [AW-1:0]    ea [NPORTS];
  logic [NPORTS-1:0] last, elig;
  logic [DEPTH-1:0] valid;
  logic [AW-1:0]    sel_ea;
  logic [DW-1:0]    sel_wd;
  logic [CW-1:0]    sel_cnt;
  logic [PW-1:0]    sel_port;
  logic             any_st, any_ld;
  logic             rvalid_q, rvalid_nx;
  logic [PW-1:0]    rport_q, rport_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    ssm_port_seq #(.AW(AW), .LW(LW)) u_seq (
      .clk(clk), .rst_n(rst_i), .req(req[p]), .gnt(gnt[p]),
      .base(req_addr[p*AW +: AW]), .len(req_len[p*LW +: LW]),
      .ea(ea[p]), .last(last[p])
    );
    assign elig[p] = req[p] &&
      ((op_e'(req_st[p]) == OP_STORE) ? !valid[ea[p]] : valid[ea[p]]);
  end

  ssm_rr_arb #(.NPORTS(NPORTS)) u_arb (
    .clk(clk), .rst_n(rst_i), .en(!init), .elig(elig), .gnt(gnt)
  );

  always_comb begin
    sel_ea = '0; sel_wd = '0; sel_cnt = '0; sel_port = '0;
    any_st = 1'b0; any_ld = 1'b0;
    for (int p = 0; p < NPORTS; p++) begin
      if (gnt[p]) begin
        sel_ea   = ea[p];
        sel_wd   = st_data[p*DW +: DW];
        sel_cnt  = st_cnt[p*CW +: CW];
        sel_port = PW'(p);
        if (op_e'(req_st[p]) == OP_STORE) any_st = 1'b1;
        else                              any_ld = 1'b1;
      end
    end
  end

  ssm_tag_mem #(.AW(AW), .DW(DW), .CW(CW)) u_mem (
    .clk(clk), .rst_n(rst_i), .init(init), .wr_en(any_st), .rd_en(any_ld),
    .addr(sel_ea), .wdata(sel_wd), .cnt_in(sel_cnt),
    .valid_o(valid), .rdata_o(rd_data)
  );

  always_comb begin
    rvalid_nx = any_ld;
    rport_nx  = any_ld ? sel_port : rport_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rvalid_q <= 1'b0;
      rport_q  <= '0;
    end else begin
      rvalid_q <= rvalid_nx;
      rport_q  <= rport_nx;
    end
  end

  assign done     = gnt & last;
  assign rd_valid = rvalid_q;
  assign rd_port  = rport_q;

  a_r3_data_next_cycle: assert property (@(posedge clk) disable iff (!rst_i)
    any_ld |=> (rd_valid && rd_port == $past(sel_port)));
  a_r9_no_grant_in_init: assert property (@(posedge clk) disable iff (!rst_i)
    init |-> gnt == '0);
  a_r1_quiet_without_load: assert property (@(posedge clk) disable iff (!rst_i)
    !any_ld |=> !rd_valid);
endmodule

// File: tb/sim_ssm_sync_scratchpad.sv
module sim_ssm_sync_scratchpad;
  localparam int N = 3, AW = 3, DW = 16, CW = 2, LW = 3, PW = 2, DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_init = 1'b0;
  logic b_req [N];
  logic b_st  [N];
  logic [AW-1:0] b_addr [N];
  logic [LW-1:0] b_len  [N];
  logic [DW-1:0] b_wd   [N];
  logic [CW-1:0] b_cnt  [N];
  bit   busy [N];

  logic [N-1:0]    req, req_st, gnt, done;
  logic [N*AW-1:0] req_addr;
  logic [N*LW-1:0] req_len;
  logic [N*DW-1:0] st_data;
  logic [N*CW-1:0] st_cnt;
  logic            rd_valid;
  logic [PW-1:0]   rd_port;
  logic [DW-1:0]   rd_data;

  int n_chk = 0, n_fail = 0, multi_err = 0;
  bit rst_done = 1'b0;
  logic [DW-1:0] model [DEPTH];
  int exp_port [$];
  logic [DW-1:0] exp_data [$];
  int glog [$];

  always #2 clk = ~clk;

  always_comb begin
    for (int p = 0; p < N; p++) begin
      req[p] = b_req[p];
      req_st[p] = b_st[p];
      req_addr[p*AW +: AW] = b_addr[p];
      req_len[p*LW +: LW]  = b_len[p];
      st_data[p*DW +: DW]  = b_wd[p];
      st_cnt[p*CW +: CW]   = b_cnt[p];
    end
  end

  ssm_sync_scratchpad #(.NPORTS(N), .AW(AW), .DW(DW), .CW(CW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .init(b_init), .req(req), .req_st(req_st),
    .req_addr(req_addr), .req_len(req_len), .st_data(st_data), .st_cnt(st_cnt),
    .gnt(gnt), .done(done), .rd_valid(rd_valid), .rd_port(rd_port), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic port_op(input int p, input bit st, input int a, input int l,
                         input logic [DW-1:0] base, input int c);
    busy[p] = 1'b1;
    b_st[p] = st; b_addr[p] = AW'(a); b_len[p] = LW'(l); b_cnt[p] = CW'(c);
    b_wd[p] = base; b_req[p] = 1'b1;
    for (int k = 0; k <= l; k++) begin
      int ea;
      b_wd[p] = base + DW'(k);
      do @(negedge clk); while (!gnt[p]);
      glog.push_back(p);
      ea = (a + k) % DEPTH;
      if (st) model[ea] = base + DW'(k);
      else begin
        exp_port.push_back(p);
        exp_data.push_back(model[ea]);
      end
      chk(done[p] == (k == l), "R6 done flag", 32'(done[p]), 32'(k == l));
      @(posedge clk); #1;
    end
    b_req[p] = 1'b0;
    busy[p] = 1'b0;
  endtask

  task automatic expect_stall(input int p, input int n, input string rq);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!gnt[p], rq, 32'(gnt[p]), 32'd0);
    end
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (rst_done) begin
      if ($countones(gnt) > 1) multi_err++;
      if (rd_valid) begin
        if (exp_data.size() == 0) begin
          chk(1'b0, "R3 unexpected read data", 32'(rd_data), 32'hffff_ffff);
        end else begin
          int ep;
          logic [DW-1:0] ed;
          ep = exp_port.pop_front();
          ed = exp_data.pop_front();
          chk(rd_data == ed, "R3 R4 R6 R7 read data", 32'(rd_data), 32'(ed));
          chk(int'(rd_port) == ep, "R3 read port", 32'(rd_port), 32'(ep));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int p = 0; p < N; p++) begin
      b_req[p] = 1'b0; b_st[p] = 1'b0; b_addr[p] = '0; b_len[p] = '0;
      b_wd[p] = '0; b_cnt[p] = '0; busy[p] = 1'b0;
    end
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_done = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(!rd_valid, "R1 rd_valid after reset", 32'(rd_valid), 32'd0);
    chk(gnt == '0, "R1 no grant after reset", 32'(gnt), 32'd0);
    settle();

    // R3: load to absent word stalls, then completes after store
    fork port_op(0, 1'b0, 3, 0, '0, 0); join_none
    expect_stall(0, 3, "R3 load to absent word");
    settle();
    port_op(1, 1'b1, 3, 0, 16'h1111, 2);
    wait (!busy[0]); settle();
    port_op(2, 1'b0, 3, 0, '0, 0);
    // R4: count exhausted, further load stalls until re-store
    fork port_op(0, 1'b0, 3, 0, '0, 0); join_none
    expect_stall(0, 3, "R4 load after count exhausted");
    settle();
    port_op(1, 1'b1, 3, 0, 16'h2222, 1);
    wait (!busy[0]); settle();

    // R2: count zero is taken as one
    port_op(0, 1'b1, 5, 0, 16'h0505, 0);
    port_op(1, 1'b0, 5, 0, '0, 0);
    fork port_op(2, 1'b0, 5, 0, '0, 0); join_none
    expect_stall(2, 3, "R2 zero count serves one read");
    settle();
    port_op(0, 1'b1, 5, 0, 16'h0555, 1);
    wait (!busy[2]); settle();

    // R5: store to present word stalls
    port_op(0, 1'b1, 6, 0, 16'h0606, 1);
    fork port_op(1, 1'b1, 6, 0, 16'h0666, 1); join_none
    expect_stall(1, 3, "R5 store to present word");
    settle();
    port_op(2, 1'b0, 6, 0, '0, 0);
    wait (!busy[1]); settle();
    port_op(0, 1'b0, 6, 0, '0, 0);

    // R6: burst wrapping past the top address
    port_op(0, 1'b1, 6, 3, 16'h0A00, 1);
    port_op(1, 1'b0, 6, 3, '0, 0);

    // R7: stalled burst resumes from held element
    port_op(0, 1'b1, 2, 0, 16'h0B00, 1);
    fork port_op(2, 1'b0, 2, 2, '0, 0); join_none
    repeat (3) @(posedge clk);
    expect_stall(2, 3, "R7 burst stalled mid-way");
    settle();
    port_op(0, 1'b1, 3, 1, 16'h0C00, 1);
    wait (!busy[2]); settle();

    // R8: round-robin rotation among three contending stores
    glog.delete();
    fork
      port_op(0, 1'b1, 0, 1, 16'h1000, 1);
      port_op(1, 1'b1, 5, 1, 16'h2000, 1);
      port_op(2, 1'b1, 2, 1, 16'h3000, 1);
    join
    chk(glog.size() == 6, "R8 grant count", 32'(glog.size()), 32'd6);
    for (int i = 1; i < glog.size(); i++)
      chk(glog[i] == (glog[i-1] + 1) % N, "R8 rotation order", 32'(glog[i]), 32'((glog[i-1] + 1) % N));
    fork
      port_op(0, 1'b0, 0, 1, '0, 0);
      port_op(1, 1'b0, 5, 1, '0, 0);
      port_op(2, 1'b0, 2, 1, '0, 0);
    join

    // R9: init clears presence and blocks grants that cycle
    port_op(0, 1'b1, 4, 0, 16'h4444, 3);
    b_init = 1'b1;
    fork port_op(1, 1'b1, 7, 0, 16'h7777, 1); join_none
    @(negedge clk);
    chk(gnt == '0, "R9 no grant during init", 32'(gnt), 32'd0);
    settle();
    b_init = 1'b0;
    wait (!busy[1]); settle();
    fork port_op(2, 1'b0, 4, 0, '0, 0); join_none
    expect_stall(2, 3, "R9 word absent after init");
    settle();
    port_op(0, 1'b1, 4, 0, 16'h4545, 1);
    wait (!busy[2]); settle();
    port_op(0, 1'b0, 7, 0, '0, 0);

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(exp_data.size() == 0, "R3 all loads returned", 32'(exp_data.size()), 32'd0);
    chk(multi_err == 0, "R10 single grant per cycle", 32'(multi_err), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule